// File: doc/BRIEF.md
# Overlapped Windowed Frame Builder

This block sits at the front of a speech feature pipeline. It accepts one signed 16-bit audio sample at a time, applies a first-order high-frequency boost (pre-emphasis) to each sample exactly once, and stores the result in a two-half ring buffer. Frames are 256 samples long and start every 128 samples. Each frame therefore uses the older stored half followed by the newest half, and each pre-emphasized value serves two consecutive frames.

When a frame is complete, a read sequencer streams the 256 samples out in order, one per clock. Each sample is multiplied by a Hamming coefficient. The coefficients live in a 128-entry table and are addressed in mirror order for the second half of the frame. The windowed stream feeds a 256-point transform and is marked with a start-of-frame flag and a last flag. The output runs at the clock rate and the input arrives far slower, so new samples keep landing in the ring while a frame is being read out.

Top module: `frame_window_builder`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `out_valid`, `out_sof` and `out_last` are 0.
- R2: Each accepted sample x gives y = x - p + (p >>> 5). p is the previously accepted sample, and the shift is arithmetic. y saturates to the range -32768..32767.
- R3: The previous-sample value p is 0 after reset. It carries across frame boundaries and is updated only by accepted samples.
- R4: The first frame is emitted after the 256th accepted sample. After that, one frame is emitted after every further 128 accepted samples and at no other time.
- R5: The frame emitted after accepted sample k (counting from 1) carries, in arrival order, the pre-emphasized values of samples k-255 through k.
- R6: Output position n (0..255) uses coefficient c[m], where m = n for n < 128 and m = 255 - n otherwise. c[m] = round((0.54 - 0.46*cos(2*pi*m/255)) * 1023), a 10-bit unsigned value.
- R7: The output sample is (y*c + 512) >>> 10, an arithmetic shift, as a signed 16-bit value.
- R8: A frame is 256 back-to-back `out_valid` cycles. `out_sof` is high on the first of them only, and `out_last` is high on the 256th only.
- R9: The first output sample of a frame appears two clock edges after the edge that accepts the sample completing the frame.
- R10: With at least 3 clocks between accepted samples, samples that arrive during frame output are kept. Later frames contain them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_data | input | 16 | Signed audio sample |
| out_valid | output | 1 | Windowed sample valid |
| out_data | output | 16 | Signed windowed sample |
| out_last | output | 1 | Marks sample 255 of a frame |
| out_sof | output | 1 | Marks sample 0 of a frame |

## Verification
Two functions can fall in the same cycle here: a new sample being written into the ring, and the read sequencer fetching the older half of the frame that is streaming out. The bench provokes this by feeding samples with gaps of only 3 to 6 clocks. Samples therefore arrive throughout every frame readout, and with the minimum gap the write address trails just behind the read address. A behavioural model keeps every pre-emphasized value in arrival order and compares each output beat. Any sample overwritten too early, or any lost input, shows up as a data mismatch in that frame or in the next one.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  // Mirror a frame position onto the half-length coefficient table.
  function automatic logic [6:0] mirror_idx7(input logic [7:0] pos);
    return pos[7] ? ~pos[6:0] : pos[6:0];
  endfunction

  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } beat_tag_t;

endpackage

// File: rtl/fwb_preemph.sv
module fwb_preemph #(
  parameter int W     = 16,
  parameter int SHIFT = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_data,
  output logic signed [W-1:0] emph_data
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] HI = EW'((1 <<< (W-1)) - 1);
  localparam logic signed [EW-1:0] LO = -EW'(1 <<< (W-1));

  logic signed [W-1:0]  last_q;
  logic signed [EW-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst)            last_q <= '0;
    else if (smp_valid) last_q <= smp_data;
  end

  always_comb begin
    diff = EW'(smp_data) - EW'(last_q) + EW'(last_q >>> SHIFT);
    if (diff > HI)      emph_data = HI[W-1:0];
    else if (diff < LO) emph_data = LO[W-1:0];
    else                emph_data = diff[W-1:0];
  end
endmodule

// File: rtl/fwb_ring_ram.sv
module fwb_ring_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/fwb_window_rom.sv
module fwb_window_rom #(
  parameter int CW    = 10,
  parameter int FRAME = 256,
  localparam int HALF = FRAME / 2,
  localparam int HW   = $clog2(HALF)
) (
  input  logic          clk,
  input  logic [HW-1:0] addr,
  output logic [CW-1:0] coef
);
  localparam real TWO_PI = 6.283185307179586;
  localparam real SCALE  = real'((1 << CW) - 1);

  logic [CW-1:0] table_q [HALF];

  initial begin
    for (int i = 0; i < HALF; i++) begin
      table_q[i] = CW'($rtoi((0.54 - 0.46 * $cos(TWO_PI * real'(i) / real'(FRAME - 1)))
                             * SCALE + 0.5));
    end
  end

  always_ff @(posedge clk) coef <= table_q[addr];
endmodule

// File: rtl/fwb_window_mult.sv
module fwb_window_mult #(
  parameter int W  = 16,
  parameter int CW = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  fwb_pkg::beat_tag_t  tag_in,
  input  logic signed [W-1:0] smp,
  input  logic [CW-1:0]       coef,
  output logic                o_valid,
  output logic                o_sof,
  output logic                o_last,
  output logic [W-1:0]        o_data
);
  localparam int PW = W + CW + 1;
  localparam logic signed [PW-1:0] HALF_LSB = PW'(1 <<< (CW-1));

  logic signed [PW-1:0] prod;

  always_comb prod = PW'(smp) * $signed({1'b0, coef}) + HALF_LSB;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_last  <= 1'b0;
      o_data  <= '0;
    end else begin
      o_valid <= tag_in.valid;
      o_sof   <= tag_in.valid & tag_in.first;
      o_last  <= tag_in.valid & tag_in.last;
      o_data  <= tag_in.valid ? prod[CW+W-1:CW] : '0;
    end
  end
endmodule

// File: rtl/frame_window_builder.sv
module frame_window_builder #(
  parameter int W     = 16,
  parameter int CW    = 10,
  parameter int FRAME = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         out_sof
);
  localparam int AW   = $clog2(FRAME);
  localparam int HALF = FRAME / 2;
  localparam int HW   = $clog2(HALF);

  logic signed [W-1:0] emph;
  logic [AW-1:0]       wr_ptr;
  logic                primed;
  logic                rd_busy;
  logic [AW-1:0]       rd_cnt;
  logic [AW-1:0]       rd_base;
  logic [W-1:0]        ram_q;
  logic [CW-1:0]       coef_q;
  logic [HW-1:0]       coef_addr;
  fwb_pkg::beat_tag_t  tag_q;
  logic                half_done;

  fwb_preemph #(.W(W)) u_emph (
    .clk(clk), .rst(rst), .smp_valid(in_valid),
    .smp_data($signed(in_data)), .emph_data(emph)
  );

  fwb_ring_ram #(.W(W), .DEPTH(FRAME)) u_ring (
    .clk(clk), .wr_en(in_valid), .wr_addr(wr_ptr), .wr_data(emph),
    .rd_addr(rd_base + rd_cnt), .rd_data(ram_q)
  );

  // Second half of a frame walks the table backwards.
  always_comb coef_addr = rd_cnt[HW] ? ~rd_cnt[HW-1:0] : rd_cnt[HW-1:0];

  fwb_window_rom #(.CW(CW), .FRAME(FRAME)) u_rom (
    .clk(clk), .addr(coef_addr), .coef(coef_q)
  );

  always_comb half_done = in_valid & (&wr_ptr[HW-1:0]);

  // Write side: fill the ring and launch a frame on each completed half.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      primed <= 1'b0;
    end else if (in_valid) begin
      wr_ptr <= wr_ptr + AW'(1);
      if (half_done) primed <= 1'b1;
    end
  end

  // Read side: one beat per clock for a whole frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_busy <= 1'b0;
      rd_cnt  <= '0;
      rd_base <= '0;
    end else if (half_done && primed) begin
      rd_busy <= 1'b1;
      rd_cnt  <= '0;
      rd_base <= wr_ptr + AW'(1);
    end else if (rd_busy) begin
      rd_cnt <= rd_cnt + AW'(1);
      if (rd_cnt == AW'(FRAME - 1)) rd_busy <= 1'b0;
    end
  end

  // Tag travels alongside the RAM and ROM read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else begin
      tag_q.valid <= rd_busy;
      tag_q.first <= rd_busy && (rd_cnt == '0);
      tag_q.last  <= rd_busy && (rd_cnt == AW'(FRAME - 1));
    end
  end

  fwb_window_mult #(.W(W), .CW(CW)) u_mult (
    .clk(clk), .rst(rst), .tag_in(tag_q), .smp($signed(ram_q)),
    .coef(coef_q), .o_valid(out_valid), .o_sof(out_sof),
    .o_last(out_last), .o_data(out_data)
  );
endmodule

// File: rtl/fwb_checker.sv
module fwb_checker #(
  parameter int FRAME = 256
) (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic out_last,
  input logic out_sof
);
  localparam int BW = $clog2(FRAME) + 1;

  logic [BW-1:0] beats_q;
  logic          in_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      beats_q  <= '0;
      in_frame <= 1'b0;
    end else if (out_valid) begin
      beats_q  <= out_sof ? BW'(1) : beats_q + BW'(1);
      in_frame <= !out_last;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sof && !out_last));

  p_sof_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  p_contiguous_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  p_mid_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> in_frame);

  p_last_position_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (beats_q == BW'(FRAME - 1)));

  p_gap_after_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> !out_valid);
endmodule

bind frame_window_builder fwb_checker #(.FRAME(FRAME)) u_fwb_checker (
  .clk(clk), .rst(rst), .out_valid(out_valid),
  .out_last(out_last), .out_sof(out_sof)
);

// File: tb/tb_frame_window_builder.sv
module tb_frame_window_builder;
  localparam int NSAMP = 1024;
  localparam real TWO_PI = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid, out_last, out_sof;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;

  int coef [128];
  int hist [NSAMP];
  int frame_exp [256];

  always #10 clk = ~clk;

  frame_window_builder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_sof(out_sof)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int gen_sample(input int i);
    if (i < 300)      return int'($signed(16'($urandom)));
    else if (i < 420) return (i % 2 == 0) ? 32767 : -32768;
    else if (i < 560) return 1000;
    else if (i < 700) return (i % 3 == 0) ? -32768 : -20000;
    else              return int'($signed(16'($urandom))) / 16;
  endfunction

  function automatic int sat16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int prev = 0;
    int n_sent = 0;
    int gap = 0;
    int start_in = 0;
    int emit_cnt = 0;
    int emit_idx = 0;
    int tail = 0;

    for (int m = 0; m < 128; m++)
      coef[m] = $rtoi((0.54 - 0.46 * $cos(TWO_PI * real'(m) / 255.0)) * 1023.0 + 0.5);

    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_sof == 1'b0 && out_last == 1'b0, "R1 flags", int'({out_sof, out_last}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after release", int'(out_valid), 0);

    while (tail < 40) begin
      @(negedge clk);
      if (start_in > 0) begin
        start_in--;
        if (start_in == 0) begin
          emit_cnt = 256;
          emit_idx = 0;
        end
      end

      // R4 R9 R10: out_valid only during the expected frame window
      check(out_valid == (emit_cnt > 0), "R4 R9 R10 out_valid", int'(out_valid), int'(emit_cnt > 0));
      if (emit_cnt > 0) begin
        check(int'($signed(out_data)) == frame_exp[emit_idx], "R2 R3 R5 R6 R7 data",
              int'($signed(out_data)), frame_exp[emit_idx]);
        check(out_sof == (emit_idx == 0), "R8 out_sof", int'(out_sof), int'(emit_idx == 0));
        check(out_last == (emit_idx == 255), "R8 out_last", int'(out_last), int'(emit_idx == 255));
        emit_idx++;
        emit_cnt--;
      end else begin
        check(!out_sof && !out_last, "R8 idle flags", int'({out_sof, out_last}), 0);
      end

      in_valid = 1'b0;
      if (n_sent < NSAMP) begin
        if (gap > 0) begin
          gap--;
        end else begin
          int x, y;
          x = gen_sample(n_sent);
          // R2: pre-emphasis, R3: previous sample kept across frames
          y = sat16(x - prev + (prev >>> 5));
          prev = x;
          hist[n_sent] = y;
          in_valid = 1'b1;
          in_data = 16'(x);
          n_sent++;
          gap = 2 + int'($urandom % 4);
          if (n_sent >= 256 && (n_sent % 128) == 0) begin
            for (int n = 0; n < 256; n++) begin
              int c;
              c = (n < 128) ? coef[n] : coef[255 - n];
              frame_exp[n] = (hist[n_sent - 256 + n] * c + 512) >>> 10;
            end
            start_in = 3;
          end
        end
      end else if (start_in == 0 && emit_cnt == 0) begin
        tail++;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule